// File: doc/BRIEF.md
# Coprocessor Serial Command Master

This block lets a host issue single-register writes and reads to a speech-recognition coprocessor over a four-wire serial link. The host offers a request made of a direction flag, an 8-bit register address and, for writes, an 8-bit value. The block accepts it when `req_ready` is high and turns it into one framed transfer: a command byte, the address byte and a data byte. For a read, the byte returned by the device is presented on `resp_rdata` with a one-cycle `resp_valid` strobe when the frame closes. Writes produce the same strobe with a zero data byte.

The serial clock is derived from the system clock by a parameterised half-period count. An elaboration check rejects any setting whose serial rate would exceed the device limit of 1.5 MHz. The device shifts in on the falling edge and updates its output on the rising edge, so the master moves its outgoing bit on rising edges and samples the returned bit on falling edges. The device also holds its output line low while deselected, so the master reads that line only during the data byte of a read.

The block also owns two side-band lines. It drives the device's active-low reset for a programmed number of system clocks after power-up or after `rst_req`, and it accepts no request until that reset is released. It passes the active-low interrupt from the device through a synchroniser and raises a single-cycle pulse when the interrupt is asserted.

Top module: `cop_spi_master`

## Requirements
- R1: While and directly after system reset, `spi_cs_n` is 1, `spi_sclk` is 1, `spi_mosi` is 0, `resp_valid` is 0, `irq_fall` is 0, `cop_rst_n` is 0 and `req_ready` is 0.
- R2: An accepted write produces one frame of exactly 24 falling serial clock edges with `spi_cs_n` low throughout, carrying MSB first the command byte 0x04, then the address byte, then the write value.
- R3: An accepted read sends command byte 0x05, then the address byte, then eight zero bits. It samples `spi_miso` on falling edges 17 to 24 of the frame, MSB first, and returns that byte on `resp_rdata` in the cycle where `resp_valid` is high.
- R4: `spi_sclk` is high whenever `spi_cs_n` is high, so the first edge of every frame is a falling edge. `spi_mosi` never changes at a falling serial clock edge.
- R5: Each high phase and each low phase of `spi_sclk` inside a frame lasts exactly HALF_DIV system clocks. Elaboration fails if CLK_HZ / (2*HALF_DIV) exceeds SCLK_MAX_HZ.
- R6: `spi_miso` has no effect outside falling edges 17 to 24 of a read frame. A write returns `resp_rdata` 0x00 even when the line is held high.
- R7: `resp_valid` is a one-cycle pulse in the first cycle with `spi_cs_n` high after a frame. `req_ready` stays low for exactly 2*HALF_DIV cycles starting with that cycle, so chip select stays high for at least one full serial period between frames.
- R8: `req_ready` is low from acceptance until the end of the gap. A request held valid during that time starts no frame, and a frame starts only after a cycle with both `req_valid` and `req_ready` high.
- R9: `cop_rst_n` is low for exactly RST_HOLD clocks after a one-cycle `rst_req` pulse, and also after system reset. While it is low, `req_ready` is 0 and no frame starts.
- R10: `irq_n` passes through SYNC_STAGES flops onto `irq_level_n`. A falling edge of `irq_n` gives one `irq_fall` pulse exactly SYNC_STAGES clocks later, and a rising edge gives none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_valid | input | 1 | Host offers a transfer request |
| req_ready | output | 1 | Block will accept a request this cycle |
| req_write | input | 1 | 1 selects a register write, 0 a register read |
| req_addr | input | 8 | Coprocessor register address |
| req_wdata | input | 8 | Value to write (ignored for reads) |
| resp_valid | output | 1 | One-cycle strobe at the end of each frame |
| resp_rdata | output | 8 | Byte returned by a read, 0x00 after a write |
| rst_req | input | 1 | Pulse that restarts the coprocessor reset hold |
| cop_rst_n | output | 1 | Active-low reset to the coprocessor |
| irq_n | input | 1 | Active-low interrupt from the coprocessor, asynchronous |
| irq_level_n | output | 1 | Synchronised interrupt level |
| irq_fall | output | 1 | One-cycle pulse on interrupt assertion |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Host-to-device data |
| spi_miso | input | 1 | Device-to-host data |

## Verification
The properties assume that `rst_req` is pulsed only while no frame is running. They also assume that `spi_miso` changes only on rising serial clock edges or while chip select is high, which is how the device behaves. The bench's device model drives the line only on those events and issues reset pulses only from idle. Outside the read data byte the model drives the line high rather than low, so any stray sample would show up in the returned byte. Interrupt edges are applied away from transfers and at least SYNC_STAGES+1 cycles apart, because the single-pulse property assumes no narrower glitches.

// File: rtl/cop_spi_pkg.sv
package cop_spi_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h04;
   localparam logic [BYTE_W-1:0] CMD_READ  = 8'h05;

   typedef enum logic [2:0] {
      ENG_IDLE,
      ENG_SETUP,
      ENG_LOW,
      ENG_HIGH,
      ENG_END,
      ENG_GAP
   } eng_state_t;
endpackage

// File: rtl/cop_rst_seq.sv
module cop_rst_seq #(
   parameter int HOLD = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic dev_rst_n
);
   localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
   localparam logic [CW-1:0] LOAD = CW'(HOLD - 1);

   logic [CW-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain    <= LOAD;
         dev_rst_n <= 1'b0;
      end else if (restart) begin
         remain    <= LOAD;
         dev_rst_n <= 1'b0;
      end else if (remain != '0) begin
         remain <= remain - 1'b1;
      end else begin
         dev_rst_n <= 1'b1;
      end
   end
endmodule

// File: rtl/cop_irq_sync.sv
module cop_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic irq_async_n,
   output logic level_n,
   output logic fall_pulse
);
   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '1;
         last_q <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], irq_async_n};
         last_q <= chain[STAGES-1];
      end
   end

   assign level_n    = chain[STAGES-1];
   assign fall_pulse = last_q & ~chain[STAGES-1];
endmodule

// File: rtl/cop_spi_engine.sv
module cop_spi_engine
   import cop_spi_pkg::*;
#(
   parameter int HALF_DIV = 67
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              start_valid,
   output logic              start_ready,
   input  logic              is_write,
   input  logic [BYTE_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic              done,
   output logic [BYTE_W-1:0] rdata,
   output logic              cs_n,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso
);
   localparam int FRAME_BITS = 3 * BYTE_W;
   localparam int BIT_W      = $clog2(FRAME_BITS);
   localparam int CNT_W      = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
   localparam logic [CNT_W-1:0] HALF_LIM   = CNT_W'(HALF_DIV - 1);
   localparam logic [CNT_W-1:0] GAP_LIM    = CNT_W'(2 * HALF_DIV - 1);
   localparam logic [BIT_W-1:0] LAST_BIT   = BIT_W'(FRAME_BITS - 1);
   localparam logic [BIT_W-1:0] FIRST_DATA = BIT_W'(2 * BYTE_W);

   eng_state_t            state;
   logic [CNT_W-1:0]      cnt;
   logic [BIT_W-1:0]      bit_idx;
   logic [FRAME_BITS-1:0] shreg;
   logic [BYTE_W-1:0]     rx;
   logic                  rd_mode;
   logic                  tick;

   assign tick        = (cnt == ((state == ENG_GAP) ? GAP_LIM : HALF_LIM));
   assign start_ready = (state == ENG_IDLE) && enable;
   assign mosi        = cs_n ? 1'b0 : shreg[FRAME_BITS-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         cnt     <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         rx      <= '0;
         rd_mode <= 1'b0;
         cs_n    <= 1'b1;
         sclk    <= 1'b1;
         done    <= 1'b0;
         rdata   <= '0;
      end else begin
         done <= 1'b0;
         if (state == ENG_IDLE) begin
            cnt <= '0;
            if (start_valid && start_ready) begin
               shreg   <= {is_write ? CMD_WRITE : CMD_READ, addr,
                           is_write ? wdata : {BYTE_W{1'b0}}};
               rd_mode <= !is_write;
               rx      <= '0;
               bit_idx <= '0;
               cs_n    <= 1'b0;
               state   <= ENG_SETUP;
            end
         end else if (!tick) begin
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= '0;
            case (state)
               ENG_SETUP, ENG_HIGH: begin
                  sclk  <= 1'b0;
                  state <= ENG_LOW;
                  if (rd_mode && (bit_idx >= FIRST_DATA))
                     rx <= {rx[BYTE_W-2:0], miso};
               end
               ENG_LOW: begin
                  sclk <= 1'b1;
                  if (bit_idx == LAST_BIT) begin
                     state <= ENG_END;
                  end else begin
                     bit_idx <= bit_idx + 1'b1;
                     shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
                     state   <= ENG_HIGH;
                  end
               end
               ENG_END: begin
                  cs_n  <= 1'b1;
                  done  <= 1'b1;
                  rdata <= rx;
                  state <= ENG_GAP;
               end
               default: state <= ENG_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/cop_spi_master.sv
module cop_spi_master
   import cop_spi_pkg::*;
#(
   parameter int CLK_HZ      = 200_000_000,
   parameter int SCLK_MAX_HZ = 1_500_000,
   parameter int HALF_DIV    = 67,
   parameter int RST_HOLD    = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [BYTE_W-1:0] req_addr,
   input  logic [BYTE_W-1:0] req_wdata,
   output logic              resp_valid,
   output logic [BYTE_W-1:0] resp_rdata,
   input  logic              rst_req,
   output logic              cop_rst_n,
   input  logic              irq_n,
   output logic              irq_level_n,
   output logic              irq_fall,
   output logic              spi_cs_n,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if (longint'(CLK_HZ) > longint'(SCLK_MAX_HZ) * 2 * longint'(HALF_DIV)) begin : g_too_fast
      $error("serial clock would exceed SCLK_MAX_HZ; raise HALF_DIV");
   end
   if (RST_HOLD < 1) begin : g_bad_hold
      $error("RST_HOLD must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   cop_rst_seq #(.HOLD(RST_HOLD)) i_rst_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (rst_req),
      .dev_rst_n (cop_rst_n)
   );

   cop_irq_sync #(.STAGES(SYNC_STAGES)) i_irq_sync (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_async_n (irq_n),
      .level_n     (irq_level_n),
      .fall_pulse  (irq_fall)
   );

   cop_spi_engine #(.HALF_DIV(HALF_DIV)) i_engine (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable      (cop_rst_n),
      .start_valid (req_valid),
      .start_ready (req_ready),
      .is_write    (req_write),
      .addr        (req_addr),
      .wdata       (req_wdata),
      .done        (resp_valid),
      .rdata       (resp_rdata),
      .cs_n        (spi_cs_n),
      .sclk        (spi_sclk),
      .mosi        (spi_mosi),
      .miso        (spi_miso)
   );
endmodule

// File: rtl/cop_spi_checker.sv
module cop_spi_checker #(
   parameter int HALF_DIV = 67
) (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_ready,
   input logic resp_valid,
   input logic cop_rst_n,
   input logic irq_level_n,
   input logic irq_fall,
   input logic spi_cs_n,
   input logic spi_sclk,
   input logic spi_mosi
);
   localparam int RUN_W = $clog2(HALF_DIV + 1) + 1;
   localparam logic [RUN_W-1:0] RUN_MIN = RUN_W'(HALF_DIV);

   logic             sclk_q;
   logic [RUN_W-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         run    <= RUN_MIN;
      end else begin
         sclk_q <= spi_sclk;
         if (spi_sclk != sclk_q) run <= RUN_W'(1);
         else if (run < RUN_MIN) run <= run + 1'b1;
      end
   end

   assert_idle_clk_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> spi_sclk);

   assert_mosi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_sclk) |-> $stable(spi_mosi));

   assert_half_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (spi_sclk != sclk_q) |-> (run >= RUN_MIN));

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   assert_done_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spi_cs_n) |-> resp_valid);

   assert_busy_refuse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_cs_n |-> !req_ready);

   assert_frame_needs_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(spi_cs_n) |-> $past(req_valid && req_ready));

   assert_hold_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !cop_rst_n |-> !req_ready);

   assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fall |-> !irq_level_n);

   assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fall |=> !irq_fall);
endmodule

bind cop_spi_master cop_spi_checker #(.HALF_DIV(HALF_DIV)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .resp_valid  (resp_valid),
   .cop_rst_n   (cop_rst_n),
   .irq_level_n (irq_level_n),
   .irq_fall    (irq_fall),
   .spi_cs_n    (spi_cs_n),
   .spi_sclk    (spi_sclk),
   .spi_mosi    (spi_mosi)
);

// File: tb/test_cop_spi_master.sv
`timescale 1ns/1ps
module test_cop_spi_master;
   localparam int HALF = 67;
   localparam int HOLD = 16;
   localparam int STG  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_write = 1'b0;
   logic [7:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       rst_req = 1'b0;
   logic       irq_n = 1'b1;
   logic       req_ready, resp_valid, cop_rst_n, irq_level_n, irq_fall;
   logic [7:0] resp_rdata;
   logic       spi_cs_n, spi_sclk, spi_mosi, spi_miso;

   int n_checks = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   cop_spi_master #(.HALF_DIV(HALF), .RST_HOLD(HOLD), .SYNC_STAGES(STG)) i_cop_spi_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata), .rst_req(rst_req),
      .cop_rst_n(cop_rst_n), .irq_n(irq_n), .irq_level_n(irq_level_n),
      .irq_fall(irq_fall), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso)
   );

   // device model: captures on falling edges, drives on rising edges,
   // holds the line high outside the read data byte
   logic [23:0] cap = '0;
   int          nfall = 0;
   int          nedge = 0;
   int          frames = 0;
   logic        first_is_fall = 1'b0;
   logic [7:0]  dev_op = '0;
   logic [7:0]  dev_addr = '0;
   logic [7:0]  rd_val;
   logic        miso_r = 1'b1;

   assign rd_val   = dev_addr ^ 8'hA5;
   assign spi_miso = miso_r;

   always @(negedge spi_cs_n) begin
      nfall = 0;
      nedge = 0;
      frames++;
   end

   always @(spi_sclk) begin
      if (spi_cs_n === 1'b0) begin
         if (nedge == 0) first_is_fall = (spi_sclk === 1'b0);
         nedge++;
      end
   end

   always @(negedge spi_sclk) begin
      if (spi_cs_n === 1'b0) begin
         cap = {cap[22:0], spi_mosi};
         nfall++;
         if (nfall == 8)  dev_op = cap[7:0];
         if (nfall == 16) dev_addr = cap[7:0];
      end
   end

   always @(posedge spi_sclk or posedge spi_cs_n) begin
      if (spi_cs_n !== 1'b0) miso_r = 1'b1;
      else if (dev_op == 8'h05 && nfall >= 16 && nfall < 24) miso_r = rd_val[23 - nfall];
      else miso_r = 1'b1;
   end

   // length of the last low phase of the serial clock, in system clocks
   int lowrun = 0;
   int last_low = 0;
   always @(negedge clk) begin
      if (spi_cs_n === 1'b0 && spi_sclk === 1'b0) lowrun++;
      else if (lowrun != 0) begin
         last_low = lowrun;
         lowrun = 0;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   endtask

   task automatic do_txn(input logic w, input logic [7:0] a, input logic [7:0] d,
                         output logic [7:0] rd);
      int gap;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
      rd = resp_rdata;
      check(spi_cs_n && spi_sclk, "R4 idle lines after frame", {spi_cs_n, spi_sclk}, 2'b11);
      check(first_is_fall, "R4 first edge in frame is falling", first_is_fall, 1);
      gap = 0;
      while (!req_ready) begin
         gap++;
         @(negedge clk);
         if (gap == 1) check(!resp_valid, "R7 done pulse one cycle", resp_valid, 0);
      end
      check(gap == 2 * HALF, "R7 gap before ready", gap, 2 * HALF);
   endtask

   // {write, addr, wdata, expected rdata}
   localparam logic [24:0] VEC [9] = '{
      {1'b1, 8'h17, 8'h80, 8'h00},
      {1'b0, 8'h3C, 8'h00, 8'h99},
      {1'b1, 8'hFF, 8'h01, 8'h00},
      {1'b0, 8'h00, 8'h00, 8'hA5},
      {1'b0, 8'hFF, 8'h00, 8'h5A},
      {1'b1, 8'h00, 8'h00, 8'h00},
      {1'b0, 8'h5A, 8'h00, 8'hFF},
      {1'b0, 8'hA5, 8'h00, 8'h00},
      {1'b1, 8'hAA, 8'h55, 8'h00}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      int fb;
      int n;
      logic ok;

      repeat (4) @(negedge clk);
      // R1 reset values
      check(spi_cs_n && spi_sclk && !spi_mosi, "R1 serial lines in reset",
            {spi_cs_n, spi_sclk, spi_mosi}, 3'b110);
      check(!resp_valid && !irq_fall && !cop_rst_n && !req_ready, "R1 strobes in reset",
            {resp_valid, irq_fall, cop_rst_n, req_ready}, 0);
      rst_n = 1'b1;

      // R9: request while the device reset is still held is refused
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h42; req_wdata = 8'h24;
      @(negedge clk);
      check(spi_cs_n && !cop_rst_n, "R1 state right after reset release",
            {spi_cs_n, cop_rst_n}, 2'b10);
      ok = 1'b1;
      while (!cop_rst_n) begin
         if (req_ready) ok = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(ok, "R9 ready low during reset hold", ok, 1);
      repeat (10) @(negedge clk);
      check(frames == 0, "R9 no frame while reset held", frames, 0);

      // R10 interrupt synchroniser
      irq_n = 1'b0;
      n = 0;
      ok = 1'b0;
      while (n < 6 && !ok) begin
         @(negedge clk);
         n++;
         ok = irq_fall;
      end
      check(n == STG, "R10 pulse latency", n, STG);
      check(!irq_level_n, "R10 synchronised level", irq_level_n, 0);
      @(negedge clk);
      check(!irq_fall, "R10 pulse width", irq_fall, 0);
      irq_n = 1'b1;
      ok = 1'b0;
      repeat (6) begin
         @(negedge clk);
         if (irq_fall) ok = 1'b1;
      end
      check(!ok && irq_level_n, "R10 no pulse on release", {ok, irq_level_n}, 1);

      // table walk
      for (int i = 0; i < 9; i++) begin
         logic [7:0] exp_frame_d;
         fb = frames;
         do_txn(VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
         exp_frame_d = VEC[i][24] ? VEC[i][15:8] : 8'h00;
         check(frames == fb + 1, "R8 one frame per request", frames, fb + 1);
         check(nfall == 24, "R2 falling edges per frame", nfall, 24);
         if (VEC[i][24]) begin
            check(cap == {8'h04, VEC[i][23:16], exp_frame_d}, "R2 write frame bits",
                  cap, {8'h04, VEC[i][23:16], exp_frame_d});
            check(rd == 8'h00, "R6 write returns zero despite high line", rd, 8'h00);
         end else begin
            check(cap == {8'h05, VEC[i][23:16], 8'h00}, "R3 read frame bits",
                  cap, {8'h05, VEC[i][23:16], 8'h00});
            check(rd == VEC[i][7:0], "R3 R6 read data", rd, VEC[i][7:0]);
         end
      end
      check(last_low == HALF, "R5 low phase length", last_low, HALF);

      // R8: request held during a frame is refused
      fb = frames;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h12; req_wdata = 8'h34;
      @(negedge clk);
      req_addr = 8'h77; req_wdata = 8'h88;
      ok = 1'b1;
      while (!resp_valid) begin
         if (req_ready) ok = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b0;
      check(ok, "R8 ready low during frame", ok, 1);
      while (!req_ready) @(negedge clk);
      repeat (5) @(negedge clk);
      check(frames == fb + 1, "R8 held request not taken", frames, fb + 1);
      check(cap == 24'h041234, "R8 first request framed", cap, 24'h041234);

      // R9 reset request pulse
      rst_req = 1'b1;
      @(negedge clk);
      rst_req = 1'b0;
      n = 0;
      while (!cop_rst_n && n < 1000) begin
         n++;
         if (req_ready) ok = 1'b0;
         @(negedge clk);
      end
      check(n == HOLD, "R9 reset hold length", n, HOLD);
      @(negedge clk);
      check(req_ready, "R9 ready after release", req_ready, 1);

      // a read after the device reset still works
      fb = frames;
      do_txn(1'b0, 8'h81, 8'hFF, rd);
      check(rd == 8'h24, "R3 read after reset", rd, 8'h24);
      check(cap == 24'h058100, "R3 read ignores write value", cap, 24'h058100);

      finish_run();
   end
endmodule